// File: doc/BRIEF.md
# Tick-Driven Two-Group ADC Scan Sequencer

This block drives an on-chip multi-channel converter that digitises four channels per scan. A periodic tick launches a scan of the first channel group. When the converter reports completion, the sequencer stores that group's results and launches the second group by itself. After the second group completes it stops and waits for the next tick. Every channel is therefore refreshed once per tick period, with no software involvement between the two groups.

The converter's raw results arrive left-justified in 16-bit words. The sequencer keeps the top 10 bits of each one in an eight-entry result store. Any channel can be read through a registered read port. Each converter lane has its own small memory bank, and the group number is the address within that bank. The control word sent to the converter is cleared for one cycle on every completion before the next group is launched.

Top module: `adc_grp_scan_seq`

## Requirements
- R1: A tick sampled while the sequencer is idle produces, on the next cycle, a one-cycle `conv_start_o` pulse with `conv_scan_en_o` = 1 and `conv_grp_o` = 0. Scan enable stays high until the matching `conv_done_i`.
- R2: A `conv_done_i` during the group-0 scan stores raw lane k (`raw_i[16k+15:16k]`) into channel slot k, for k = 0..3.
- R3: After the group-0 completion, `conv_start_o`, `conv_scan_en_o` and `conv_grp_o` are all 0 for exactly one cycle. On the following cycle `conv_start_o` pulses with `conv_scan_en_o` = 1 and `conv_grp_o` = 1.
- R4: A `conv_done_i` during the group-1 scan stores raw lane k into slot 4+k and clears the control word. No further start pulse occurs until the next tick.
- R5: The stored value is the raw word shifted right by 6, which is raw bits [15:6] as a 10-bit result.
- R6: A tick that arrives while a two-group scan is in progress is ignored. The scan is neither restarted nor extended.
- R7: `conv_done_i` is ignored while idle and during the one-cycle gap between groups. No slot changes in those cycles.
- R8: `rd_data_o` presents the most recently stored value of channel `rd_ch_i` one cycle after `rd_ch_i` is applied. It reads 0 for every channel not written since reset.
- R9: Over consecutive tick periods with different raw data, every one of the eight channels is refreshed once per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic tick strobe |
| conv_done_i | input | 1 | Converter reports the current group finished |
| raw_i | input | 64 | Four 16-bit left-justified raw results, lane k at bits 16k+15:16k |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_scan_en_o | output | 1 | Scan mode and completion notification enabled |
| conv_grp_o | output | 1 | Channel group being converted (0: ch 0-3, 1: ch 4-7) |
| rd_ch_i | input | 3 | Channel number to read |
| rd_data_o | output | 10 | Stored result of the selected channel |

## Verification
Assertions check the control sequence on every cycle. A tick in idle leads to a group-0 launch, and a group-0 completion leads to one cleared cycle followed by a group-1 launch. A final completion returns the block to idle, start pulses last one cycle, and a tick during a scan produces no start. Assertions also check that the store's valid flags follow the write strobe. Only the bench scenarios can show the stored data itself. These cover the shift-by-6 scaling across lanes and slots, values kept through ignored completions and ticks, zeros after reset, and all eight channels refreshed on each of several ticks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Progress of one tick's multi-group scan
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // waiting for a tick
    PH_RUN  = 2'd1,  // a group is converting, waiting for done
    PH_GAP  = 2'd2   // control word cleared, next group launches next cycle
  } scan_phase_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int GRP_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic             conv_scan_en_o,
  output logic [GRP_W-1:0] conv_grp_o,
  output logic             wr_en_o,
  output logic [GRP_W-1:0] wr_grp_o
);

  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GRP - 1);

  scan_phase_e      phase_q;
  logic [GRP_W-1:0] grp_q;       // group being worked on
  logic             start_q;
  logic             scan_q;
  logic [GRP_W-1:0] ctrl_grp_q;  // group field of the control word
  logic             last_grp;

  assign last_grp = (grp_q == LAST_GRP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      grp_q      <= '0;
      start_q    <= 1'b0;
      scan_q     <= 1'b0;
      ctrl_grp_q <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (tick_i) begin
            phase_q    <= PH_RUN;
            grp_q      <= '0;
            start_q    <= 1'b1;
            scan_q     <= 1'b1;
            ctrl_grp_q <= '0;
          end
        end
        PH_RUN: begin
          if (conv_done_i) begin
            scan_q     <= 1'b0;
            ctrl_grp_q <= '0;
            phase_q    <= last_grp ? PH_IDLE : PH_GAP;
          end
        end
        PH_GAP: begin
          phase_q    <= PH_RUN;
          grp_q      <= grp_q + 1'b1;
          start_q    <= 1'b1;
          scan_q     <= 1'b1;
          ctrl_grp_q <= grp_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign conv_start_o   = start_q;
  assign conv_scan_en_o = scan_q;
  assign conv_grp_o     = ctrl_grp_q;
  assign wr_en_o        = (phase_q == PH_RUN) && conv_done_i;
  assign wr_grp_o       = grp_q;

  // R1: an idle tick launches group 0
  p_launch_grp0_r1: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == PH_IDLE) |=> (conv_start_o && conv_scan_en_o && conv_grp_o == '0));

  // R1: start is a single-cycle pulse that always comes with scan enable
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);
  p_start_scan_r1: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> conv_scan_en_o);

  // R3: a non-final completion clears the word for one cycle, then relaunches
  p_clear_then_next_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN && conv_done_i && !last_grp)
      |=> (!conv_start_o && !conv_scan_en_o && conv_grp_o == '0)
      ##1 (conv_start_o && conv_scan_en_o && conv_grp_o == $past(grp_q, 2) + 1'b1));

  // R4: the final completion clears the word and returns to idle
  p_stop_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN && conv_done_i && last_grp)
      |=> (!conv_scan_en_o && !conv_start_o && phase_q == PH_IDLE));

  // R6: a tick during a running group produces no start
  p_tick_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && phase_q == PH_RUN) |=> !conv_start_o);

  // R7: done outside a running group writes nothing
  p_done_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_RUN) |-> !wr_en_o);

endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
  parameter int DEPTH = 2,
  parameter int DW    = 10,
  parameter int AW    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  // Data array has no reset so it can map to block RAM; a flag per entry
  // gives the zero-after-reset view.
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    rd_q;
  logic             rd_vld_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rd_q <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (we_i) vld_q[waddr_i] <= 1'b1;
      rd_vld_q <= vld_q[raddr_i];
    end
  end

  assign rdata_o = rd_vld_q ? rd_q : '0;

  // R8: a written entry is marked valid from the next cycle on
  p_write_marks_valid_r8: assert property (@(posedge clk) disable iff (rst)
    we_i |=> vld_q[$past(waddr_i)]);

endmodule

// File: rtl/adc_grp_scan_seq.sv
module adc_grp_scan_seq #(
  parameter int CH_PER_GRP = 4,   // power of two
  parameter int NUM_GRP    = 2,   // power of two
  parameter int RAW_W      = 16,
  parameter int RES_W      = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_i,
  input  logic                        conv_done_i,
  input  logic [CH_PER_GRP*RAW_W-1:0] raw_i,
  output logic                        conv_start_o,
  output logic                        conv_scan_en_o,
  output logic [((NUM_GRP > 1) ? $clog2(NUM_GRP) : 1)-1:0] conv_grp_o,
  input  logic [((CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1)
                + ((NUM_GRP > 1) ? $clog2(NUM_GRP) : 1)-1:0] rd_ch_i,
  output logic [RES_W-1:0]            rd_data_o
);

  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int LANE_W = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1;
  localparam int CH_W   = LANE_W + GRP_W;
  localparam int SHIFT  = RAW_W - RES_W;

  logic             wr_en;
  logic [GRP_W-1:0] wr_grp;
  logic [LANE_W-1:0] rd_lane;
  logic [GRP_W-1:0]  rd_grp;
  logic [LANE_W-1:0] lane_sel_q;
  logic [RES_W-1:0]  lane_rd [CH_PER_GRP];

  assign rd_lane = rd_ch_i[LANE_W-1:0];
  assign rd_grp  = rd_ch_i[CH_W-1:LANE_W];

  adc_seq_ctrl #(
    .NUM_GRP (NUM_GRP),
    .GRP_W   (GRP_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .conv_done_i    (conv_done_i),
    .conv_start_o   (conv_start_o),
    .conv_scan_en_o (conv_scan_en_o),
    .conv_grp_o     (conv_grp_o),
    .wr_en_o        (wr_en),
    .wr_grp_o       (wr_grp)
  );

  // One bank per converter lane; the group number addresses within it.
  for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_lane
    logic [RAW_W-1:0] raw_lane;
    logic [RES_W-1:0] scaled;
    logic             unused_lsbs;

    assign raw_lane    = raw_i[k*RAW_W +: RAW_W];
    assign scaled      = raw_lane[RAW_W-1:SHIFT];
    assign unused_lsbs = ^raw_lane[SHIFT-1:0];

    adc_seq_bank #(
      .DEPTH (NUM_GRP),
      .DW    (RES_W),
      .AW    (GRP_W)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we_i    (wr_en),
      .waddr_i (wr_grp),
      .wdata_i (scaled),
      .raddr_i (rd_grp),
      .rdata_o (lane_rd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lane_sel_q <= '0;
    else     lane_sel_q <= rd_lane;
  end

  assign rd_data_o = lane_rd[lane_sel_q];

endmodule

// File: tb/adc_grp_scan_seq_tb.sv
module adc_grp_scan_seq_tb;

  localparam int NCH = 8;

  // Raw words per tick scenario: [scenario][channel]
  localparam logic [15:0] VEC [0:3][0:7] = '{
    '{16'hFFFF, 16'h0040, 16'h003F, 16'h8000, 16'h1234, 16'hABCD, 16'h7FC0, 16'h00C1},
    '{16'h0000, 16'hFFC0, 16'h5555, 16'hAAAA, 16'h0FFF, 16'hF000, 16'h0100, 16'h4321},
    '{16'h8040, 16'h2468, 16'h1357, 16'hC0C0, 16'h0041, 16'hFF80, 16'h3C3C, 16'h9999},
    '{16'h7777, 16'h0001, 16'hE000, 16'h0C00, 16'hBEEF, 16'h0080, 16'hFFFE, 16'h6000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_i;
  logic        conv_done_i;
  logic [63:0] raw_i;
  logic        conv_start_o;
  logic        conv_scan_en_o;
  logic [0:0]  conv_grp_o;
  logic [2:0]  rd_ch_i;
  logic [9:0]  rd_data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_grp_scan_seq u_dut (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .conv_done_i    (conv_done_i),
    .raw_i          (raw_i),
    .conv_start_o   (conv_start_o),
    .conv_scan_en_o (conv_scan_en_o),
    .conv_grp_o     (conv_grp_o),
    .rd_ch_i        (rd_ch_i),
    .rd_data_o      (rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_grp(input int e, input int g);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) w[k*16 +: 16] = VEC[e][g*4 + k];
    return w;
  endfunction

  function automatic int ctl_word();
    return {29'd0, conv_start_o, conv_scan_en_o, conv_grp_o};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_ch(input int ch, input int exp, input string req);
    rd_ch_i = 3'(ch);
    @(negedge clk);
    chk(rd_data_o == 10'(exp), req, int'(rd_data_o), exp);
  endtask

  // Expected slot contents, computed as raw >> 6
  int exp_slot [NCH];

  task automatic read_all(input string req);
    for (int c = 0; c < NCH; c++) read_ch(c, exp_slot[c], req);
  endtask

  // Complete one group that is already launched: wait, then a done pulse
  task automatic finish_grp(input logic [63:0] w);
    cyc(3);
    raw_i = w;
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
  endtask

  task automatic full_tick(input int e);
    bit saw_start;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(ctl_word() == 6, "R1 launch grp0 {start,scan,grp}", ctl_word(), 6);
    @(negedge clk);
    chk(ctl_word() == 2, "R1 scan held, start dropped", ctl_word(), 2);
    finish_grp(pack_grp(e, 0));
    chk(ctl_word() == 0, "R3 word cleared after grp0", ctl_word(), 0);
    @(negedge clk);
    chk(ctl_word() == 7, "R3 launch grp1 {start,scan,grp}", ctl_word(), 7);
    finish_grp(pack_grp(e, 1));
    chk(ctl_word() == 0, "R4 word cleared after grp1", ctl_word(), 0);
    saw_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (conv_start_o) saw_start = 1'b1;
    end
    chk(!saw_start, "R4 no start before next tick", int'(saw_start), 0);
    for (int c = 0; c < NCH; c++) exp_slot[c] = int'(VEC[e][c] >> 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_i = 1'b0; conv_done_i = 1'b0; raw_i = '0; rd_ch_i = '0;
    for (int c = 0; c < NCH; c++) exp_slot[c] = 0;
    cyc(4);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk(ctl_word() == 0, "R1 reset control word", ctl_word(), 0);
    read_all("R8 zero after reset");

    // Table walk: every tick refreshes all channels with new data
    for (int e = 0; e < 4; e++) begin
      full_tick(e);
      if (e == 0) read_all("R2 R5 slots after first tick");
      else        read_all("R9 R4 refresh every channel");
    end

    // Done while idle is ignored
    raw_i = {4{16'hFFFF}};
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    chk(ctl_word() == 0, "R7 no launch from idle done", ctl_word(), 0);
    read_all("R7 slots kept after idle done");

    // Tick during a running group is ignored
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    cyc(1);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(ctl_word() == 2, "R6 mid-scan tick no restart", ctl_word(), 2);
    finish_grp(pack_grp(1, 0));
    @(negedge clk);
    chk(ctl_word() == 7, "R6 grp1 launches once", ctl_word(), 7);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk(ctl_word() == 3, "R6 tick in grp1 ignored", ctl_word(), 3);
    finish_grp(pack_grp(1, 1));
    cyc(2);
    chk(!conv_start_o, "R6 no extra scan after ignored tick", int'(conv_start_o), 0);
    for (int c = 0; c < NCH; c++) exp_slot[c] = int'(VEC[1][c] >> 6);
    read_all("R6 slots from completed scan");

    // Done held into the gap cycle: the second cycle is ignored
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    cyc(2);
    raw_i = pack_grp(2, 0);
    conv_done_i = 1'b1;
    @(negedge clk);
    raw_i = pack_grp(3, 0);
    @(negedge clk);
    conv_done_i = 1'b0;
    chk(ctl_word() == 7, "R3 grp1 launch after held done", ctl_word(), 7);
    finish_grp(pack_grp(2, 1));
    for (int c = 0; c < NCH; c++) exp_slot[c] = int'(VEC[2][c] >> 6);
    cyc(1);
    read_all("R7 gap-cycle done ignored");

    // Reset clears the store view
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) exp_slot[c] = 0;
    read_all("R8 zero after second reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule